// File: doc/BRIEF.md
# Configurable Approximate Ripple Adder

This block adds two operands of a chosen width, with a carry-in, and produces the sum and a carry-out. It is built so that a chosen number of low-order result bits come from cheaper, approximate logic, while the bits above them are computed exactly. It targets error-tolerant datapaths such as filter tap sums. In these datapaths a small, bounded error in the low bits is acceptable in exchange for a shorter carry path and less logic.

Three approximate schemes can be chosen for the low part. The first is a carry-guessing cell whose carry ignores the incoming carry. The second is a cell whose sum bit is the inverse of an exact majority carry. The third is a windowed scheme of overlapping 4-bit sub-adders that each guess their own incoming carry from the two bits below them. A mode parameter chooses how many low bits are approximate: none, half the width, a custom count, or all of them. The result is registered once, so every addition appears one clock after its operands. Illegal configurations stop elaboration.

Top module: `apx_adder`

## Requirements
- R1: The sum and carry-out are registered outputs. Operands and carry-in sampled at a rising clock edge appear on the outputs right after that edge. While reset is low, both outputs are held at zero.
- R2: With zero approximate bits (mode none), {cout_o, sum_o} equals opa + opb + cin exactly, for any scheme.
- R3: Carry-guessing scheme (SCHEME value 1): each approximate bit cell outputs sum = a XOR b XOR cin_bit and carry = a AND b. Its carry therefore differs from a true full adder only for (cin_bit, a, b) = (1,0,1) and (1,1,0).
- R4: Inverted-sum scheme (SCHEME value 2): each approximate bit cell outputs carry = majority(a, b, cin_bit) and sum = NOT carry. Its sum therefore differs from a true full adder only for (cin_bit, a, b) = (0,0,0) and (1,1,1).
- R5: Windowed scheme (SCHEME value 3) over an approximate region of M bits uses (M-4)/2+1 exact 4-bit windows. Window 0 adds bits 3..0 with cin and supplies result bits 3..0. Window j>=1 adds bits 2j+3..2j with a carry-in of zero and supplies only its top two sum bits, as result bits 2j+3..2j+2.
- R6: The approximate-bit count is 0 for mode none (MODE value 0), WIDTH/2 for half (1), CUSTOM_BITS for custom (2) and WIDTH for all (3). The approximate bits are always the lowest ones.
- R7: The bits above the approximate region form an exact ripple adder. Its carry-in is the carry out of the top approximate cell, or the full carry of the top window. cout_o is the carry out of the top bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; results register on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the outputs |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
Every result is due at the first rising edge after its operands are applied, so the latency is one cycle for every scheme and width. The bench changes operands on the falling edge. For each applied operand set it queues the expected result of every instance. The monitor pops that entry a quarter period after the following rising edge, when the registered outputs are stable. The single-bit cells are combinational and are checked directly against their truth tables, one input combination at a time.

// File: rtl/apx_pkg.sv
package apx_pkg;

    typedef enum int {
        SCH_EXACT  = 0,
        SCH_CPRED  = 1,
        SCH_INVSUM = 2,
        SCH_SEG    = 3
    } scheme_e;

    typedef enum int {
        MODE_NONE   = 0,
        MODE_HALF   = 1,
        MODE_CUSTOM = 2,
        MODE_ALL    = 3
    } mode_e;

    // window geometry of the segmented scheme
    localparam int SEG_RES  = 2;
    localparam int SEG_PRED = 2;
    localparam int SEG_LEN  = SEG_RES + SEG_PRED;

    function automatic int apx_width(input int w, input mode_e m, input int custom);
        case (m)
            MODE_NONE:   return 0;
            MODE_HALF:   return w / 2;
            MODE_CUSTOM: return custom;
            default:     return w;
        endcase
    endfunction

endpackage

// File: rtl/apx_cell.sv
module apx_cell
    import apx_pkg::*;
#(
    parameter scheme_e SCHEME = SCH_EXACT
) (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic maj;
    assign maj = (a & b) | (a & ci) | (b & ci);

    if (SCHEME == SCH_CPRED) begin : g_cpred
        assign s  = a ^ b ^ ci;
        assign co = a & b;
    end else if (SCHEME == SCH_INVSUM) begin : g_invsum
        assign co = maj;
        assign s  = ~maj;
    end else begin : g_exact
        assign s  = a ^ b ^ ci;
        assign co = maj;
    end
endmodule

// File: rtl/apx_cell_chain.sv
module apx_cell_chain
    import apx_pkg::*;
#(
    parameter int      WIDTH  = 6,
    parameter scheme_e SCHEME = SCH_EXACT
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] s,
    output logic             cout
);
    logic [WIDTH:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        apx_cell #(.SCHEME(SCHEME)) u_cell (
            .a (a[i]),
            .b (b[i]),
            .ci(c[i]),
            .s (s[i]),
            .co(c[i+1])
        );
    end

    assign cout = c[WIDTH];
endmodule

// File: rtl/apx_seg_lane.sv
module apx_seg_lane
    import apx_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] s,
    output logic             cout
);
    localparam int L = SEG_LEN;
    localparam int K = (WIDTH - L) / SEG_RES + 1;

    logic [L:0] win [K];

    for (genvar j = 0; j < K; j++) begin : g_win
        if (j == 0) begin : g_first
            assign win[j] = {1'b0, a[L-1:0]} + {1'b0, b[L-1:0]} + {{L{1'b0}}, cin};
            assign s[L-1:0] = win[j][L-1:0];
        end else begin : g_next
            assign win[j] = {1'b0, a[j*SEG_RES +: L]} + {1'b0, b[j*SEG_RES +: L]};
            assign s[j*SEG_RES+SEG_PRED +: SEG_RES] = win[j][L-1:SEG_PRED];
        end
    end

    assign cout = win[K-1][L];
endmodule

// File: rtl/apx_adder.sv
module apx_adder
    import apx_pkg::*;
#(
    parameter int      WIDTH       = 12,
    parameter scheme_e SCHEME      = SCH_CPRED,
    parameter mode_e   MODE        = MODE_HALF,
    parameter int      CUSTOM_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int LOW_W  = apx_width(WIDTH, MODE, CUSTOM_BITS);
    localparam int HIGH_W = WIDTH - LOW_W;
    localparam bit SEG_OK = (LOW_W == 0) ||
                            ((LOW_W >= SEG_LEN) && ((LOW_W - SEG_LEN) % SEG_RES == 0) &&
                             (HIGH_W == 0 || HIGH_W >= SEG_LEN));
    localparam bit CFG_OK = (LOW_W >= 0) && (LOW_W <= WIDTH) && (WIDTH >= 1) &&
                            (SCHEME != SCH_SEG || SEG_OK);

    if (!CFG_OK) begin : g_bad_cfg
        $error("apx_adder: illegal width, scheme or approximate-bit count");
    end

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
    } res_t;

    logic [WIDTH-1:0] sum_c;
    logic             mid_c;
    logic             cout_c;
    res_t             res_d, res_q;

    // low, approximate region
    if (LOW_W == 0) begin : g_low_none
        assign mid_c = cin;
    end else if (SCHEME == SCH_SEG) begin : g_low_seg
        apx_seg_lane #(.WIDTH(LOW_W)) u_low (
            .a   (opa[LOW_W-1:0]),
            .b   (opb[LOW_W-1:0]),
            .cin (cin),
            .s   (sum_c[LOW_W-1:0]),
            .cout(mid_c)
        );
    end else begin : g_low_cells
        apx_cell_chain #(.WIDTH(LOW_W), .SCHEME(SCHEME)) u_low (
            .a   (opa[LOW_W-1:0]),
            .b   (opb[LOW_W-1:0]),
            .cin (cin),
            .s   (sum_c[LOW_W-1:0]),
            .cout(mid_c)
        );
    end

    // high, exact region
    if (HIGH_W == 0) begin : g_high_none
        assign cout_c = mid_c;
    end else begin : g_high_exact
        apx_cell_chain #(.WIDTH(HIGH_W), .SCHEME(SCH_EXACT)) u_high (
            .a   (opa[WIDTH-1:LOW_W]),
            .b   (opb[WIDTH-1:LOW_W]),
            .cin (mid_c),
            .s   (sum_c[WIDTH-1:LOW_W]),
            .cout(cout_c)
        );
    end

    always_comb begin
        res_d      = res_q;
        res_d.sum  = sum_c;
        res_d.cout = cout_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cout;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && !cout_o));

    if (LOW_W == 0) begin : g_chk_none
        // R2
        exact_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> ({cout_o, sum_o} ==
                       $past({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin})));
    end

    if (LOW_W > 0 && HIGH_W > 0) begin : g_chk_high
        // R7
        upper_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> ({cout_o, sum_o[WIDTH-1:LOW_W]} ==
                       $past({1'b0, opa[WIDTH-1:LOW_W]} + {1'b0, opb[WIDTH-1:LOW_W]} +
                             {{HIGH_W{1'b0}}, mid_c})));
    end

    if (SCHEME == SCH_CPRED && LOW_W >= 2) begin : g_chk_cpred
        // R3
        cpred_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (sum_o[1:0] == $past({opa[1] ^ opb[1] ^ (opa[0] & opb[0]),
                                            opa[0] ^ opb[0] ^ cin})));
    end

    if (SCHEME == SCH_INVSUM && LOW_W >= 1) begin : g_chk_invsum
        // R4
        invsum_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (sum_o[0] == $past(~((opa[0] & opb[0]) | (opa[0] & cin) | (opb[0] & cin)))));
    end

    if (SCHEME == SCH_SEG && LOW_W >= SEG_LEN) begin : g_chk_seg
        // R5
        seg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> ({1'b0, sum_o[SEG_LEN-1:0]} ==
                       $past({1'b0, opa[SEG_LEN-1:0]} + {1'b0, opb[SEG_LEN-1:0]} +
                             {{SEG_LEN{1'b0}}, cin}) % (SEG_LEN+1)'(1 << SEG_LEN)));
    end
endmodule

// File: tb/sim_apx_adder.sv
module sim_apx_adder;
    import apx_pkg::*;

    localparam int NI = 7;
    // instance configurations: width, scheme, approximate-bit count
    localparam int CW [NI] = '{12, 12, 12, 24, 8, 32, 12};
    localparam int CS [NI] = '{1, 2, 3, 3, 1, 2, 3};
    localparam int CA [NI] = '{6, 8, 12, 12, 0, 32, 8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic cin = 1'b0;

    always #10 clk = ~clk;

    logic [11:0] s0, s1, s2, s6;
    logic [23:0] s3;
    logic [7:0]  s4;
    logic [31:0] s5;
    logic [NI-1:0] co;

    apx_adder #(.WIDTH(12), .SCHEME(SCH_CPRED), .MODE(MODE_HALF), .CUSTOM_BITS(0)) u0 (
        .clk(clk), .rst_n(rst_n), .opa(a[11:0]), .opb(b[11:0]), .cin(cin), .sum_o(s0), .cout_o(co[0]));
    apx_adder #(.WIDTH(12), .SCHEME(SCH_INVSUM), .MODE(MODE_CUSTOM), .CUSTOM_BITS(8)) u1 (
        .clk(clk), .rst_n(rst_n), .opa(a[11:0]), .opb(b[11:0]), .cin(cin), .sum_o(s1), .cout_o(co[1]));
    apx_adder #(.WIDTH(12), .SCHEME(SCH_SEG), .MODE(MODE_ALL), .CUSTOM_BITS(0)) u2 (
        .clk(clk), .rst_n(rst_n), .opa(a[11:0]), .opb(b[11:0]), .cin(cin), .sum_o(s2), .cout_o(co[2]));
    apx_adder #(.WIDTH(24), .SCHEME(SCH_SEG), .MODE(MODE_HALF), .CUSTOM_BITS(0)) u3 (
        .clk(clk), .rst_n(rst_n), .opa(a[23:0]), .opb(b[23:0]), .cin(cin), .sum_o(s3), .cout_o(co[3]));
    apx_adder #(.WIDTH(8), .SCHEME(SCH_CPRED), .MODE(MODE_NONE), .CUSTOM_BITS(0)) u4 (
        .clk(clk), .rst_n(rst_n), .opa(a[7:0]), .opb(b[7:0]), .cin(cin), .sum_o(s4), .cout_o(co[4]));
    apx_adder #(.WIDTH(32), .SCHEME(SCH_INVSUM), .MODE(MODE_ALL), .CUSTOM_BITS(0)) u5 (
        .clk(clk), .rst_n(rst_n), .opa(a), .opb(b), .cin(cin), .sum_o(s5), .cout_o(co[5]));
    apx_adder #(.WIDTH(12), .SCHEME(SCH_SEG), .MODE(MODE_CUSTOM), .CUSTOM_BITS(8)) u6 (
        .clk(clk), .rst_n(rst_n), .opa(a[11:0]), .opb(b[11:0]), .cin(cin), .sum_o(s6), .cout_o(co[6]));

    // standalone cells for the truth-table checks
    logic ca, cb, cc;
    logic ps, pc, vs, vc, xs, xc;
    apx_cell #(.SCHEME(SCH_CPRED))  c_pred (.a(ca), .b(cb), .ci(cc), .s(ps), .co(pc));
    apx_cell #(.SCHEME(SCH_INVSUM)) c_inv  (.a(ca), .b(cb), .ci(cc), .s(vs), .co(vc));
    apx_cell #(.SCHEME(SCH_EXACT))  c_ex   (.a(ca), .b(cb), .ci(cc), .s(xs), .co(xc));

    int n_tests = 0;
    int n_fail  = 0;
    string tags [NI] = '{"R3 R6 R7", "R4 R6 R7", "R5 R6", "R5 R6 R7", "R2 R6", "R4 R6", "R5 R6 R7"};

    typedef logic [NI-1:0][32:0] exp_t;
    exp_t sb_q [$];

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [32:0] ref_add(input int w, input int sch, input int apx,
                                             input logic [31:0] x, input logic [31:0] y,
                                             input logic ci);
        logic [32:0] r;
        logic c, s, cn;
        int   start;
        r = '0;
        c = ci;
        start = 0;
        if (sch == 3 && apx > 0) begin
            for (int j = 0; j <= (apx - 4) / 2; j++) begin
                logic [4:0] win;
                win = {1'b0, x[2*j +: 4]} + {1'b0, y[2*j +: 4]} + ((j == 0) ? {4'b0, ci} : 5'd0);
                if (j == 0) r[3:0] = win[3:0];
                else        r[2*j+2 +: 2] = win[3:2];
                c = win[4];
            end
            start = apx;
        end
        for (int i = start; i < w; i++) begin
            if (i < apx && sch == 1) begin
                s  = x[i] ^ y[i] ^ c;
                cn = x[i] & y[i];
            end else if (i < apx && sch == 2) begin
                cn = (x[i] & y[i]) | (x[i] & c) | (y[i] & c);
                s  = ~cn;
            end else begin
                s  = x[i] ^ y[i] ^ c;
                cn = (x[i] & y[i]) | (x[i] & c) | (y[i] & c);
            end
            r[i] = s;
            c = cn;
        end
        r[w] = c;
        return r;
    endfunction

    function automatic exp_t gather();
        exp_t g;
        g[0] = {20'b0, co[0], s0};
        g[1] = {20'b0, co[1], s1};
        g[2] = {20'b0, co[2], s2};
        g[3] = {8'b0,  co[3], s3};
        g[4] = {24'b0, co[4], s4};
        g[5] = {co[5], s5};
        g[6] = {20'b0, co[6], s6};
        return g;
    endfunction

    task automatic drive(input logic [31:0] x, input logic [31:0] y, input logic ci);
        exp_t e;
        @(negedge clk);
        a = x; b = y; cin = ci;
        for (int k = 0; k < NI; k++) e[k] = ref_add(CW[k], CS[k], CA[k], x, y, ci);
        sb_q.push_back(e);
    endtask

    // monitor: result due one rising edge after the operands (R1)
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e, g;
                e = sb_q.pop_front();
                g = gather();
                for (int k = 0; k < NI; k++) check({"R1 ", tags[k]}, g[k], e[k]);
            end
        end
    end

    initial begin
        #4000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // cell truth tables (R3, R4) and the exact reference cell
        for (int v = 0; v < 8; v++) begin
            logic ea, eb, ec, m;
            {ec, ea, eb} = 3'(v);
            ca = ea; cb = eb; cc = ec;
            #1;
            m = (ea & eb) | (ea & ec) | (eb & ec);
            check("R3 cell sum", {32'b0, ps}, {32'b0, ea ^ eb ^ ec});
            check("R3 cell carry", {32'b0, pc}, {32'b0, ea & eb});
            check("R3 carry wrong only for 101/110", {32'b0, pc != m},
                  {32'b0, (v == 5) || (v == 6)});
            check("R4 cell carry", {32'b0, vc}, {32'b0, m});
            check("R4 sum wrong only for 000/111", {32'b0, vs != (ea ^ eb ^ ec)},
                  {32'b0, (v == 0) || (v == 7)});
            check("R2 exact cell", {31'b0, xc, xs}, {31'b0, m, ea ^ eb ^ ec});
        end

        // reset holds outputs at zero while operands move (R1)
        a = 32'hFFFF_FFFF; b = 32'h1234_5678; cin = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        begin
            exp_t g;
            g = gather();
            for (int k = 0; k < NI; k++) check("R1 reset clears outputs", g[k], 33'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        drive(32'h0, 32'h0, 1'b0);
        drive(32'h0, 32'h0, 1'b1);
        drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        drive(32'h0000_00FF, 32'h0000_0001, 1'b0);
        drive(32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b0);

        // random patterns
        for (int t = 0; t < 400; t++) drive($urandom, $urandom, 1'($urandom));

        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule